// File: doc/BRIEF.md
# Dithered Phase Accumulator Oscillator

This block is a numerically controlled oscillator. An N-bit phase register gains a programmable increment on every clock and wraps modulo 2^N, so the increment divided by 2^N is the output frequency as a fraction of the clock. Three views of the phase leave the block: a one-cycle pulse each time the phase wraps, a square wave taken from the top phase bit, and the top W phase bits as an address for a sine table that sits outside the block.

An optional pseudo-random offset, drawn from a free-running maximal-length shift register and confined to the phase bits below the address field, can be added before the address and pulse are formed. This breaks the periodic pattern of address steps that would otherwise produce spurs, trading them for broadband noise. The stored phase never sees the offset, so turning it off returns the outputs to the exact undithered sequence.

A new increment is captured by a load strobe and is first added on the clock edge after the strobe. Control pins are plain levels and strobes; the outputs are produced every clock with no handshake, since the block has no flow to stall.

Top module: `nco_dither_top`

## Requirements
- R1: While reset is high and in the first cycle after it, pulse_o, square_o and addr_o are all 0.
- R2: With dither off, addr_o equals bits [N-1:N-W] of the phase register one clock after that phase value was stored; the phase advances by the loaded increment modulo 2^N each clock.
- R3: With dither off, pulse_o is 1 exactly in the cycles where addr_o shows a phase reached by an addition that overflowed 2^N; with increment 0x6000 (N=16) the addresses run 0x00, 0x60, 0xC0, 0x20, 0x80, 0xE0, 0x40, 0xA0, 0x00 and 3 pulses occur in every 8 cycles.
- R4: square_o is the top bit of the stored phase, aligned with addr_o, whether or not dither is on.
- R5: An increment presented with freq_load high is first added on the following clock edge; loading does not clear the phase.
- R6: With increment 0 the phase holds and no pulse appears.
- R7: With dither on, addr_o equals the undithered address or that address plus one modulo 2^W, and the stored phase is untouched: after dither is switched off the outputs match the undithered sequence exactly.
- R8: The dither source never reaches the all-zero state and, with dither on, visibly moves addr_o off the undithered address in some cycles.
- R9: A change on freq_in without freq_load has no effect on the phase increment.
- R10: The largest increment (all ones) steps the phase down by one each clock, with a pulse on every step except the step out of phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_in | input | ACC_W | Phase increment to load |
| freq_load | input | 1 | Capture freq_in on this edge |
| dith_en | input | 1 | Add pseudo-random offset below the address field |
| pulse_o | output | 1 | One-cycle pulse on phase wrap |
| square_o | output | 1 | Top bit of stored phase |
| addr_o | output | ADDR_W | Top phase bits for an external sine table |

## Verification
The hardest state to reach from the ports is the stored phase while dither is on, since only the perturbed address is visible then. The stimulus runs the oscillator with dither enabled for several hundred cycles, bounding each address against the undithered reference, then switches dither off mid-run and demands exact agreement with the reference from the next cycle, which exposes any leak of the offset into the stored phase. Increment reloads are made mid-run with a nonzero phase and with freq_in toggling without a strobe to separate capture from use.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // Galois right-shift feedback masks giving maximal-length sequences.
  function automatic logic [31:0] lfsr_taps(input int width);
    logic [31:0] m;
    case (width)
      8:       m = 32'h0000_00B8;
      12:      m = 32'h0000_0E08;
      16:      m = 32'h0000_B400;
      20:      m = 32'h0009_0000;
      24:      m = 32'h00E1_0000;
      32:      m = 32'h8020_0003;
      default: m = 32'h0000_B400;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/nco_freq_reg.sv
module nco_freq_reg #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] freq_in,
  input  logic             freq_load,
  output logic [ACC_W-1:0] k_q
);
  always_ff @(posedge clk) begin
    if (rst)            k_q <= '0;
    else if (freq_load) k_q <= freq_in;
  end

  // R5
  k_load_chk: assert property (@(posedge clk) disable iff (rst)
    freq_load |=> k_q == $past(freq_in));
  // R9
  k_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !freq_load |=> $stable(k_q));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] k,
  output logic [ACC_W-1:0] acc_q
);
  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_q + k;
  end

  // R6
  zero_step_chk: assert property (@(posedge clk) disable iff (rst)
    (k == '0) |=> $stable(acc_q));
endmodule

// File: rtl/nco_dither_src.sv
module nco_dither_src #(
  parameter int LFSR_W = 16,
  parameter int DITH_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DITH_W-1:0] dith_o
);
  import nco_pkg::*;
  localparam logic [31:0]       TAPS_ALL = lfsr_taps(LFSR_W);
  localparam logic [LFSR_W-1:0] TAPS     = TAPS_ALL[LFSR_W-1:0];
  localparam logic [LFSR_W-1:0] SEED     = {1'b1, {(LFSR_W-1){1'b0}}};

  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] state_nx;

  always_comb begin
    state_nx = {1'b0, state_q[LFSR_W-1:1]} ^ (state_q[0] ? TAPS : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= state_nx;
  end

  // Fold every state bit into the offset so all of it is used.
  always_comb begin
    dith_o = '0;
    for (int i = 0; i < LFSR_W; i++) dith_o[i % DITH_W] ^= state_q[i];
  end

  // R8
  lfsr_live_chk: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
endmodule

// File: rtl/nco_out_stage.sv
module nco_out_stage #(
  parameter int ACC_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  acc,
  input  logic [ACC_W-1:0]  offset,
  input  logic              dith_en,
  output logic              pulse_o,
  output logic              square_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ACC_W-1:0] view;
  logic [ACC_W-1:0] view_q;

  always_comb view = acc + offset;

  always_ff @(posedge clk) begin
    if (rst) begin
      view_q   <= '0;
      pulse_o  <= 1'b0;
      square_o <= 1'b0;
    end else begin
      view_q   <= view;
      pulse_o  <= (view < view_q);
      square_o <= acc[ACC_W-1];
    end
  end

  assign addr_o = view_q[ACC_W-1 -: ADDR_W];

  // R4
  msb_align_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(dith_en) |-> addr_o[ADDR_W-1] == square_o);
endmodule

// File: rtl/nco_dither_top.sv
module nco_dither_top #(
  parameter int ACC_W  = 16,
  parameter int ADDR_W = 8,
  parameter int LFSR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  freq_in,
  input  logic              freq_load,
  input  logic              dith_en,
  output logic              pulse_o,
  output logic              square_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int DITH_W = ACC_W - ADDR_W;

  logic [ACC_W-1:0] k_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] offset;

  nco_freq_reg #(.ACC_W(ACC_W)) u_freq (
    .clk(clk), .rst(rst), .freq_in(freq_in), .freq_load(freq_load), .k_q(k_q));

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .k(k_q), .acc_q(acc_q));

  generate
    if (DITH_W > 0) begin : g_dither
      logic [DITH_W-1:0] rnd;
      nco_dither_src #(.LFSR_W(LFSR_W), .DITH_W(DITH_W)) u_rnd (
        .clk(clk), .rst(rst), .dith_o(rnd));
      assign offset = dith_en ? {{ADDR_W{1'b0}}, rnd} : '0;
    end else begin : g_plain
      assign offset = '0;
    end
  endgenerate

  nco_out_stage #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst(rst), .acc(acc_q), .offset(offset), .dith_en(dith_en),
    .pulse_o(pulse_o), .square_o(square_o), .addr_o(addr_o));

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (!pulse_o && !square_o && addr_o == '0));
endmodule

// File: tb/nco_dither_top_test.sv
module nco_dither_top_test;
  localparam int N = 16;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] freq_in = '0;
  logic         freq_load = 1'b0;
  logic         dith_en = 1'b0;
  logic         pulse_o, square_o;
  logic [W-1:0] addr_o;

  nco_dither_top uut (
    .clk(clk), .rst(rst), .freq_in(freq_in), .freq_load(freq_load),
    .dith_en(dith_en), .pulse_o(pulse_o), .square_o(square_o), .addr_o(addr_o));

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int mode = 0;        // 0 exact, 1 dither bounded
  string req = "R1";
  int moved = 0;
  int pulses = 0;

  // reference model, built from R2/R3/R4/R5
  logic [N-1:0] m_acc, m_k, m_ph;
  logic         m_pl, m_sq;
  logic [W+1:0] expq[$];

  always @(posedge clk) begin
    if (rst) begin
      m_acc = '0; m_k = '0; m_ph = '0; m_pl = 1'b0; m_sq = 1'b0;
    end else begin
      m_pl  = (m_acc < m_ph);
      m_ph  = m_acc;
      m_sq  = m_acc[N-1];
      m_acc = m_acc + m_k;
      if (freq_load) m_k = freq_in;
    end
    expq.push_back({m_ph[N-1 -: W], m_sq, m_pl});
  end

  task automatic check(input string r, input logic ok, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      logic [W+1:0] e;
      logic [W-1:0] d;
      e = expq.pop_front();
      if (pulse_o) pulses++;
      if (mode == 0) begin
        check(req, {addr_o, square_o, pulse_o} == e, "addr/sq/pulse",
              int'({addr_o, square_o, pulse_o}), int'(e));
      end else begin
        d = addr_o - e[W+1:2];
        if (d != 0) moved++;
        check("R7", d <= 1, "dithered addr", int'(addr_o), int'(e[W+1:2]));
        check("R4", square_o == e[1], "square under dither",
              int'(square_o), int'(e[1]));
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [N-1:0] k);
    @(negedge clk);
    freq_in = k; freq_load = 1'b1;
    @(negedge clk);
    freq_load = 1'b0;
  endtask

  bit done = 0;

  initial begin
    cyc(4);
    // R1 reset state
    check("R1", addr_o == 0 && !pulse_o && !square_o, "reset outputs",
          int'({addr_o, square_o, pulse_o}), 0);
    rst = 1'b0;
    req = "R2";
    cyc(3);
    // R3 F = 3/8
    req = "R3";
    load(16'h6000);
    cyc(8);
    pulses = 0;
    cyc(16);
    check("R3", pulses == 6, "pulses in 16 cycles", pulses, 6);
    // R9 freq_in moves without strobe
    req = "R9";
    @(negedge clk); freq_in = 16'h1234;
    cyc(10);
    freq_in = 16'h0F0F;
    cyc(10);
    // R5 reload mid-run, phase not cleared
    req = "R5";
    load(16'h0ABC);
    cyc(30);
    // R6 zero increment
    req = "R6";
    load(16'h0000);
    cyc(3);
    pulses = 0;
    cyc(20);
    check("R6", pulses == 0, "pulses with zero step", pulses, 0);
    // R10 largest increment
    req = "R10";
    load(16'hFFFF);
    cyc(40);
    // R7/R8 dither
    req = "R2";
    load(16'h0123);
    cyc(5);
    @(negedge clk); dith_en = 1'b1;
    @(posedge clk); #1 mode = 1;
    moved = 0;
    cyc(300);
    check("R8", moved > 0, "addr moved by dither", moved, 1);
    @(negedge clk); dith_en = 1'b0;
    @(posedge clk); #1 mode = 0; req = "R7";
    cyc(60);
    done = 1;
  end

  initial begin
    int t = 0;
    while (!done && t < 20000) begin
      @(posedge clk);
      t++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", t, 0);
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule